// File: doc/BRIEF.md
# SPI Master Queue and Status Controller

This block holds the queues and live status of a single-slave SPI master. A transmit queue feeds a byte shifter, and every byte shifted in is written to a receive queue. The block has two modes. In register mode, software writes bytes through a write strobe and reads received bytes through a read strobe. In streaming (DMA) mode, an external source fills the transmit queue through a valid/ready handshake and an external sink drains the receive queue. A transfer length, loaded by a start pulse, limits how many bytes are sent and received.

Each status flag is computed on every cycle from the queue levels, the transfer counters and the shifter state. No flag is sticky and none needs clearing. A transmit-flush pulse empties the transmit queue. When the enable is dropped, the byte on the wire always finishes. In streaming mode the queued bytes are then discarded; in register mode they stay and are sent after the next enable.

Top module: `spi_fs_ctrl`

## Requirements
- R1: A one-cycle pulse on `tx_flush` leaves the transmit queue empty on the next cycle. While `tx_flush` is held at 0, the queue level does not change. A flush is only issued while `st_tx_done` is 1.
- R2: When `en` drops during a byte, that byte completes all 8 clocks, is stored in the receive queue, and `cs_n` then returns high. No new byte starts while `en` is 0.
- R3: If `en` drops in streaming mode, the transmit queue is emptied and the remaining transmit count is cleared. If it drops in register mode, the queued bytes are kept.
- R4: `st_tx_done` depends on the mode and always requires an idle shifter. In register mode it also requires an empty transmit queue. In streaming mode it also requires a remaining transmit count of zero, even if bytes are still queued.
- R5: `st_rx_done` is 1 only in streaming mode, after a `dma_start`, once `xfer_size` bytes have been received. The shifter stops after `xfer_size` bytes.
- R6: `st_rx_avail` (receive queue not empty) and `st_rx_half` (at least DEPTH/2 entries) are forced to 0 in streaming mode. In register mode they show the new level on the cycle after an `rd_en` pop.
- R7: `st_tx_space` (queue not full) and `st_tx_half` (at most DEPTH/2 entries) are 1 after reset. They show the new level on the cycle after a push.
- R8: The queues hold DEPTH (default 8) bytes. A push to a full queue and a pop from an empty queue are ignored.
- R9: The shifter uses SPI mode 0, MSB first. `sclk` idles low, its period is 2*`half_div` system clocks, and `miso` is sampled on the rising `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Shifter enable |
| dma_mode | input | 1 | 1 = streaming mode, 0 = register mode |
| half_div | input | DIVW | System clocks per half `sclk` period |
| tx_flush | input | 1 | Pulse that empties the transmit queue |
| wr_en | input | 1 | Register-mode push strobe |
| wr_data | input | 8 | Register-mode push byte |
| rd_en | input | 1 | Register-mode pop strobe |
| rx_data | output | 8 | Head of the receive queue |
| dma_start | input | 1 | Loads the transfer length into both counters |
| xfer_size | input | CNTW | Transfer length in bytes |
| src_valid | input | 1 | Streaming source has a byte |
| src_data | input | 8 | Streaming source byte |
| src_ready | output | 1 | Transmit queue accepts a source byte |
| snk_valid | output | 1 | Receive queue offers a byte to the sink |
| snk_ready | input | 1 | Sink takes the byte |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Slave select, active low |
| st_tx_done | output | 1 | Transmit complete |
| st_rx_done | output | 1 | Streaming receive complete |
| st_rx_avail | output | 1 | Receive data available (register mode) |
| st_rx_half | output | 1 | Receive queue at least half full (register mode) |
| st_tx_space | output | 1 | Transmit queue not full |
| st_tx_half | output | 1 | Transmit queue at least half empty |

## Verification
The hardest case to reach is a disable that arrives while a byte is on the wire, because the outcome depends on the mode. The stimulus polls `cs_n` until the shifter is active, drops `en` one cycle later, and waits for `cs_n` to rise. It then reads the transmit-level flags: with eight bytes queued in streaming mode they show an empty queue, and in register mode they show the kept remainder. The byte that was cut short must still appear at the receive side. A similar case is streaming mode with `st_tx_done` high while bytes are still queued. The bench sets this up with a transfer length smaller than the number of bytes it loads, then shows that a flush is the only way the level changes.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;
  // level >= half of depth
  function automatic logic lvl_at_least_half(input logic [31:0] lvl, input logic [31:0] depth);
    return (lvl * 2) >= depth;
  endfunction
  // level <= half of depth, i.e. at least half the slots are free
  function automatic logic lvl_half_free(input logic [31:0] lvl, input logic [31:0] depth);
    return (lvl * 2) <= depth;
  endfunction
endpackage

// File: rtl/spi_fs_fifo.sv
module spi_fs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] lvl
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (lvl != CW'(DEPTH));
  assign do_pop  = pop && (lvl != '0);
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr <= '0;
      rptr <= '0;
      lvl  <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      lvl <= lvl + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr] <= din;
  end
endmodule

// File: rtl/spi_fs_shifter.sv
module spi_fs_shifter #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      tx_byte,
  input  logic [DIVW-1:0] half_div,
  input  logic            miso,
  output logic            busy,
  output logic            sclk,
  output logic            mosi,
  output logic            cs_n,
  output logic            rx_valid,
  output logic [7:0]      rx_byte
);
  logic [DIVW-1:0] dcnt, lim;
  logic [2:0]      bits;
  logic [7:0]      sreg, rxs;

  assign lim  = (half_div == '0) ? '0 : half_div - 1'b1;
  assign mosi = sreg[7];
  assign cs_n = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b0; dcnt <= '0; bits <= '0;
      sreg <= '0; rxs <= '0; rx_valid <= 1'b0; rx_byte <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; sreg <= tx_byte; dcnt <= '0; bits <= '0; sclk <= 1'b0;
        end
      end else if (dcnt == lim) begin
        dcnt <= '0;
        sclk <= ~sclk;
        if (!sclk) begin
          rxs <= {rxs[6:0], miso};
        end else begin
          sreg <= {sreg[6:0], 1'b0};
          bits <= bits + 1'b1;
          if (bits == 3'd7) begin
            busy     <= 1'b0;
            rx_valid <= 1'b1;
            rx_byte  <= rxs;
          end
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_fs_ctrl.sv
module spi_fs_ctrl
  import spi_fs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIVW  = 8,
  parameter int CNTW  = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            dma_mode,
  input  logic [DIVW-1:0] half_div,
  input  logic            tx_flush,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            rd_en,
  output logic [7:0]      rx_data,
  input  logic            dma_start,
  input  logic [CNTW-1:0] xfer_size,
  input  logic            src_valid,
  input  logic [7:0]      src_data,
  output logic            src_ready,
  output logic            snk_valid,
  input  logic            snk_ready,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic            cs_n,
  output logic            st_tx_done,
  output logic            st_rx_done,
  output logic            st_rx_avail,
  output logic            st_rx_half,
  output logic            st_tx_space,
  output logic            st_tx_half
);
  // named internal events, visible to the bound checker
  logic            en_q, en_fall, drop, tx_clr;
  logic            tx_push, rx_pop, start, busy, rx_valid;
  logic [7:0]      tx_pdata, tx_head, rx_byte;
  logic [CW-1:0]   tx_lvl, rx_lvl;
  logic [CNTW-1:0] tx_left, rx_left;
  logic            rx_armed;

  assign en_fall   = en_q & ~en;
  assign drop      = en_fall & dma_mode;
  assign tx_clr    = tx_flush | drop;
  assign src_ready = dma_mode & (tx_lvl != CW'(DEPTH));
  assign tx_push   = dma_mode ? (src_valid & src_ready) : wr_en;
  assign tx_pdata  = dma_mode ? src_data : wr_data;
  assign snk_valid = dma_mode & (rx_lvl != '0);
  assign rx_pop    = dma_mode ? (snk_valid & snk_ready) : rd_en;
  assign start     = en & ~busy & (tx_lvl != '0) & (~dma_mode | (tx_left != '0));

  spi_fs_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(tx_pdata),
    .pop(start), .dout(tx_head), .lvl(tx_lvl)
  );

  spi_fs_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .push(rx_valid), .din(rx_byte),
    .pop(rx_pop), .dout(rx_data), .lvl(rx_lvl)
  );

  spi_fs_shifter #(.DIVW(DIVW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_head), .half_div(half_div),
    .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .rx_valid(rx_valid), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; tx_left <= '0; rx_left <= '0; rx_armed <= 1'b0;
    end else begin
      en_q <= en;
      if (dma_start) begin
        tx_left  <= xfer_size;
        rx_left  <= xfer_size;
        rx_armed <= 1'b1;
      end else begin
        if (drop)                    tx_left <= '0;
        else if (start && dma_mode)  tx_left <= tx_left - 1'b1;
        if (rx_valid && dma_mode && rx_left != '0) rx_left <= rx_left - 1'b1;
      end
    end
  end

  assign st_tx_done  = ~busy & (dma_mode ? (tx_left == '0) : (tx_lvl == '0));
  assign st_rx_done  = dma_mode & rx_armed & (rx_left == '0);
  assign st_rx_avail = ~dma_mode & (rx_lvl != '0);
  assign st_rx_half  = ~dma_mode & lvl_at_least_half(32'(rx_lvl), 32'(DEPTH));
  assign st_tx_space = (tx_lvl != CW'(DEPTH));
  assign st_tx_half  = lvl_half_free(32'(tx_lvl), 32'(DEPTH));
endmodule

// File: rtl/spi_fs_chk.sv
module spi_fs_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_fall,
  input logic          dma_mode,
  input logic          tx_flush,
  input logic          wr_en,
  input logic          busy,
  input logic          rx_valid,
  input logic          sclk,
  input logic [CW-1:0] tx_lvl,
  input logic [CW-1:0] rx_lvl,
  input logic          st_tx_done,
  input logic          st_rx_done,
  input logic          st_rx_avail,
  input logic          st_rx_half
);
  p_flush_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_lvl == '0));
  p_word_completes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_valid);
  p_dma_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && dma_mode) |=> (tx_lvl == '0));
  p_reg_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && !dma_mode && !tx_flush && !wr_en) |=> (tx_lvl == $past(tx_lvl)));
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_tx_done |-> !busy);
  p_rxdone_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_rx_done |-> dma_mode);
  p_rxflags_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rx_avail || st_rx_half) |-> !dma_mode);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= CW'(DEPTH)) && (rx_lvl <= CW'(DEPTH)));
  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
endmodule

bind spi_fs_ctrl spi_fs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_fall(en_fall), .dma_mode(dma_mode),
  .tx_flush(tx_flush), .wr_en(wr_en), .busy(busy), .rx_valid(rx_valid),
  .sclk(sclk), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .st_tx_done(st_tx_done),
  .st_rx_done(st_rx_done), .st_rx_avail(st_rx_avail), .st_rx_half(st_rx_half)
);

// File: tb/tb_spi_fs_ctrl.sv
`timescale 1ns/1ps
module tb_spi_fs_ctrl;
  localparam int DEPTH = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, dma_mode = 0, tx_flush = 0, wr_en = 0, rd_en = 0, dma_start = 0;
  logic src_valid = 0, snk_ready = 0;
  logic [7:0] half_div = 8'd2, wr_data = 0, src_data = 0;
  logic [15:0] xfer_size = 0;
  logic [7:0] rx_data;
  logic src_ready, snk_valid, sclk, mosi, miso, cs_n;
  logic st_tx_done, st_rx_done, st_rx_avail, st_rx_half, st_tx_space, st_tx_half;

  int total = 0, bad = 0, cyc = 0;
  bit cmp_on = 0, finished = 0;
  int mt = 0;                 // model transmit level
  logic [7:0] txq[$], rxq[$]; // model queues
  logic [7:0] sent[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign miso = mosi; // loopback

  spi_fs_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dma_mode(dma_mode), .half_div(half_div),
    .tx_flush(tx_flush), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rx_data(rx_data), .dma_start(dma_start), .xfer_size(xfer_size),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .snk_valid(snk_valid), .snk_ready(snk_ready), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .st_tx_done(st_tx_done), .st_rx_done(st_rx_done),
    .st_rx_avail(st_rx_avail), .st_rx_half(st_rx_half),
    .st_tx_space(st_tx_space), .st_tx_half(st_tx_half)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-clock reference comparison (register mode, shifter stopped)
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk("R7 tx_space", st_tx_space, mt < DEPTH);
      chk("R7 tx_half", st_tx_half, mt * 2 <= DEPTH);
      chk("R4 tx_done", st_tx_done, mt == 0);
      chk("R6 rx_avail", st_rx_avail, rxq.size() != 0);
      chk("R6 rx_half", st_rx_half, rxq.size() * 2 >= DEPTH);
    end
  end

  task automatic push_w(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(posedge clk); #1 wr_en = 0;
    if (mt < DEPTH) begin mt++; txq.push_back(b); end
  endtask

  task automatic pop_r(input string req);
    @(negedge clk);
    if (rxq.size() != 0) chk(req, rx_data, rxq[0]);
    rd_en = 1;
    @(posedge clk); #1 rd_en = 0;
    if (rxq.size() != 0) void'(rxq.pop_front());
  endtask

  task automatic src_push(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_valid = 1; src_data = seed + 8'(i * 13);
      if (src_ready) sent.push_back(src_data);
      @(posedge clk); #1 src_valid = 0;
    end
  endtask

  task automatic dstart(input logic [15:0] n);
    @(negedge clk); dma_start = 1; xfer_size = n;
    @(posedge clk); #1 dma_start = 0;
  endtask

  task automatic flush();
    @(negedge clk);
    chk("R1 flush only when tx_done", st_tx_done, 1);
    tx_flush = 1;
    @(posedge clk); #1 tx_flush = 0;
  endtask

  task automatic wait_cs(input logic v);
    for (int k = 0; k < 4000 && cs_n !== v; k++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 4000 && st_tx_done !== 1'b1; k++) @(negedge clk);
  endtask

  task automatic idle_cs_check(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (cs_n !== 1'b1) begin chk(req, cs_n, 1); break; end
    end
    chk(req, cs_n, 1);
  endtask

  initial begin
    int t0, t1;
    logic [7:0] first;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R7 reset values
    chk("R7 reset tx_space", st_tx_space, 1);
    chk("R7 reset tx_half", st_tx_half, 1);
    chk("R4 reset tx_done", st_tx_done, 1);
    chk("R6 reset rx_avail", st_rx_avail, 0);
    chk("R5 reset rx_done", st_rx_done, 0);
    chk("R9 reset cs_n", cs_n, 1);
    chk("R9 reset sclk", sclk, 0);
    cmp_on = 1;

    // R8: nine pushes into an eight-entry queue, pop of an empty queue
    for (int i = 0; i < 9; i++) push_w(8'h3C ^ 8'(i * 37));
    @(negedge clk);
    chk("R8 full push ignored", st_tx_space, 0);
    pop_r("R8 empty pop");
    @(negedge clk);
    chk("R8 empty pop ignored", st_rx_avail, 0);

    // R9: shift all eight bytes in register mode
    cmp_on = 0;
    en = 1;
    wait_cs(0);
    chk("R9 msb first", mosi, txq[0][7]);
    for (int k = 0; k < 100 && sclk !== 1'b1; k++) @(negedge clk);
    t0 = cyc;
    for (int k = 0; k < 100 && sclk !== 1'b0; k++) @(negedge clk);
    for (int k = 0; k < 100 && sclk !== 1'b1; k++) @(negedge clk);
    t1 = cyc;
    chk("R9 sclk period", t1 - t0, 2 * half_div);
    wait_done();
    repeat (2) @(negedge clk);
    en = 0;
    @(negedge clk);
    rxq = txq; txq.delete(); mt = 0;
    cmp_on = 1;
    for (int i = 0; i < 8; i++) pop_r("R9 loopback data / R6 pop");

    // R2 / R3 register mode: disable mid-byte keeps queue
    for (int i = 0; i < 3; i++) push_w(8'hA5 + 8'(i));
    cmp_on = 0;
    en = 1;
    wait_cs(0);
    @(negedge clk); en = 0;
    wait_cs(1);
    @(negedge clk); @(negedge clk);
    chk("R2 byte finished", st_rx_avail, 1);
    chk("R2 byte data", rx_data, txq[0]);
    chk("R3 reg queue kept", st_tx_done, 0);
    idle_cs_check("R2 no new byte while disabled", 40);
    en = 1;
    wait_done();
    repeat (2) @(negedge clk);
    en = 0;
    @(negedge clk);
    rxq = txq; txq.delete(); mt = 0;
    cmp_on = 1;
    for (int i = 0; i < 3; i++) pop_r("R3 kept bytes sent");
    @(negedge clk);
    cmp_on = 0;

    // R4 / R5 / R6 / R1 streaming mode
    dma_mode = 1;
    dstart(16'd3);
    @(negedge clk);
    chk("R4 dma tx_done waits count", st_tx_done, 0);
    chk("R5 rx_done before data", st_rx_done, 0);
    sent.delete();
    src_push(10, 8'h11);
    @(negedge clk);
    chk("R8 src full ignored", st_tx_space, 0);
    en = 1;
    wait_done();
    repeat (3) @(negedge clk);
    chk("R5 rx_done after size", st_rx_done, 1);
    chk("R4 dma done with queued bytes", st_tx_done, 1);
    chk("R4 dma level five left", st_tx_half, 0);
    chk("R6 rx_avail off in dma", st_rx_avail, 0);
    chk("R6 sink sees data", snk_valid, 1);
    idle_cs_check("R5 stop after size", 40);
    chk("R1 no flush keeps level", st_tx_half, 0);
    flush();
    @(negedge clk);
    chk("R1 flush empties tx_half", st_tx_half, 1);
    chk("R1 flush empties tx_space", st_tx_space, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 sink valid", snk_valid, 1);
      chk("R5 sink data", rx_data, sent[i]);
      snk_ready = 1;
      @(posedge clk); #1 snk_ready = 0;
    end
    @(negedge clk);
    chk("R5 sink drained", snk_valid, 0);

    // R3 streaming: disable mid-byte drops queue
    dstart(16'd8);
    sent.delete();
    src_push(8, 8'h40);
    en = 0;
    @(negedge clk);
    en = 1;
    wait_cs(0);
    @(negedge clk); en = 0;
    wait_cs(1);
    repeat (2) @(negedge clk);
    chk("R3 dma queue dropped", st_tx_half, 1);
    chk("R3 dma count cleared", st_tx_done, 1);
    chk("R2 dma byte finished", snk_valid, 1);
    chk("R2 dma byte data", rx_data, sent[0]);
    en = 1;
    idle_cs_check("R3 nothing left to send", 40);
    en = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule